// File: doc/BRIEF.md
# Interrupt-Driven Audio Sample Port

This block is a memory-mapped output port for an audio stream. An internal rate divider, derived from the system clock frequency and the target sample rate (44,100 samples per second by default), marks the start of each sample period by raising a "sample needed" flag. When interrupts are enabled, the port holds a level-sensitive interrupt request at priority 5 and presents vector address 074 octal for as long as the flag stays set.

Software reaches the port through two byte-wide registers on a simple register bus. The status register at address 0 carries the enable, the need flag and a sticky underrun bit. The sample register at address 1 takes the next output byte. Writing a sample puts the byte on the output at once and clears the need flag. The request is therefore withdrawn by servicing the device, not by an acknowledge. If a handler returns without writing a sample, the request is raised again as soon as the processor priority drops.

If a whole period passes without a sample being written, the port keeps playing the previous byte and records the miss in the underrun bit.

Top module: `snd_sample_port`

## Requirements
- R1: After reset, interrupts are disabled, the need flag is 1, the underrun bit is 0, sample_out is 0x80 and irq_req is 0.
- R2: A read of address 0 returns the need flag in bit 7, the enable in bit 6, the underrun bit in bit 0 and zeros in bits 5..1. A read of address 1 returns the sample that is currently output.
- R3: A write to address 0 loads bit 7 of the written byte into the interrupt enable, so 0x80 enables and 0x00 disables.
- R4: A write to address 1 puts the written byte on sample_out from the next cycle on and clears the need flag, unless a period boundary falls in the same cycle.
- R5: The need flag is set at every period boundary. With DIV = CLK_HZ / RATE_HZ, the first boundary falls in the cycle that ends DIV clock edges after reset is released, and further boundaries follow every DIV cycles.
- R6: irq_req is 1 exactly when the need flag and the enable are both 1. Once high, it stays high until a sample write or a status write.
- R7: If a period boundary falls while the need flag is still set and no sample is written in that cycle, the underrun bit (status bit 0) is set and sample_out keeps its previous value.
- R8: A status write with bit 0 set clears the underrun bit, and a write with bit 0 clear leaves it unchanged. An underrun detected in the same cycle takes precedence over the clear.
- R9: irq_level is always 5 and irq_vector is always 074 octal (decimal 60).
- R10: When a sample is written in the same cycle as a period boundary, the sample is taken, the need flag stays set and no underrun is recorded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | 1 | Register select: 0 status, 1 sample |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected register |
| irq_req | output | 1 | Level-sensitive interrupt request |
| irq_level | output | 3 | Priority of the request |
| irq_vector | output | 8 | Vector address of the request |
| sample_out | output | 8 | Current output sample for the converter |

## Verification
The bench sets CLK_HZ to 16 times RATE_HZ, so the divider is 16 and a sample period lasts 16 cycles. With so short a period, random writes produce many underruns, missed and met deadlines, and boundaries that coincide with a sample write within a few thousand cycles. The default divider of 2267 would make each of these events rare. The wrap and first-boundary timing are the same code path at any divider value.

// File: rtl/snd_port_pkg.sv
package snd_port_pkg;

    localparam int BYTE_W = 8;

    // register select on the bus
    localparam logic SEL_STATUS = 1'b0;
    localparam logic SEL_SAMPLE = 1'b1;

    // status byte bit positions
    localparam int ST_NEED_BIT  = 7;
    localparam int ST_EN_BIT    = 6;
    localparam int ST_URUN_BIT  = 0;
    localparam int ST_WR_EN_BIT = 7;

    localparam logic [BYTE_W-1:0] MID_SCALE = 8'h80;

    typedef struct packed {
        logic              need;
        logic              en;
        logic              urun;
        logic [BYTE_W-1:0] smp;
    } port_state_t;

    function automatic port_state_t port_reset_state();
        port_state_t s;
        s.need = 1'b1;
        s.en   = 1'b0;
        s.urun = 1'b0;
        s.smp  = MID_SCALE;
        return s;
    endfunction

    function automatic logic [BYTE_W-1:0] pack_status(input port_state_t s);
        logic [BYTE_W-1:0] b;
        b = '0;
        b[ST_NEED_BIT] = s.need;
        b[ST_EN_BIT]   = s.en;
        b[ST_URUN_BIT] = s.urun;
        return b;
    endfunction

endpackage

// File: rtl/snd_rate_div.sv
module snd_rate_div #(
    parameter int CLK_HZ  = 100_000_000,
    parameter int RATE_HZ = 44_100
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int DIV = (CLK_HZ / RATE_HZ < 2) ? 2 : CLK_HZ / RATE_HZ;
    localparam int CW  = $clog2(DIV);
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } div_state_t;

    div_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.cnt == LAST) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // boundary is the last cycle of each period
    assign tick = (st_q.cnt == LAST);

endmodule

// File: rtl/snd_port_regs.sv
module snd_port_regs
    import snd_port_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              bus_wr,
    input  logic              bus_addr,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    output logic              need,
    output logic              en,
    output logic              urun,
    output logic [BYTE_W-1:0] sample
);
    port_state_t st_d, st_q;
    logic wr_status, wr_sample;

    assign wr_status = bus_wr && (bus_addr == SEL_STATUS);
    assign wr_sample = bus_wr && (bus_addr == SEL_SAMPLE);

    always_comb begin
        st_d = st_q;
        if (wr_status) begin
            st_d.en = bus_wdata[ST_WR_EN_BIT];
            if (bus_wdata[ST_URUN_BIT]) begin
                st_d.urun = 1'b0;
            end
        end
        if (wr_sample) begin
            st_d.need = 1'b0;
            st_d.smp  = bus_wdata;
        end
        if (tick) begin
            // a miss needs the flag still pending and no sample this cycle
            if (st_q.need && !wr_sample) begin
                st_d.urun = 1'b1;
            end
            st_d.need = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= port_reset_state();
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        if (bus_addr == SEL_STATUS) begin
            bus_rdata = pack_status(st_q);
        end else begin
            bus_rdata = st_q.smp;
        end
    end

    assign need   = st_q.need;
    assign en     = st_q.en;
    assign urun   = st_q.urun;
    assign sample = st_q.smp;

endmodule

// File: rtl/snd_port_irq.sv
module snd_port_irq #(
    parameter int IRQ_PRIO = 5,
    parameter int IRQ_VEC  = 8'o074,
    parameter int LVL_W    = 3,
    parameter int VEC_W    = 8
) (
    input  logic             need,
    input  logic             en,
    output logic             req,
    output logic [LVL_W-1:0] level,
    output logic [VEC_W-1:0] vector
);
    assign req    = need && en;
    assign level  = LVL_W'(IRQ_PRIO);
    assign vector = VEC_W'(IRQ_VEC);
endmodule

// File: rtl/snd_sample_port.sv
module snd_sample_port
    import snd_port_pkg::*;
#(
    parameter int CLK_HZ   = 100_000_000,
    parameter int RATE_HZ  = 44_100,
    parameter int IRQ_PRIO = 5,
    parameter int IRQ_VEC  = 8'o074
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_wr,
    input  logic        bus_addr,
    input  logic [7:0]  bus_wdata,
    output logic [7:0]  bus_rdata,
    output logic        irq_req,
    output logic [2:0]  irq_level,
    output logic [7:0]  irq_vector,
    output logic [7:0]  sample_out
);
    logic tick;
    logic need, en, urun;

    snd_rate_div #(
        .CLK_HZ (CLK_HZ),
        .RATE_HZ(RATE_HZ)
    ) u_div (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick)
    );

    snd_port_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .need     (need),
        .en       (en),
        .urun     (urun),
        .sample   (sample_out)
    );

    snd_port_irq #(
        .IRQ_PRIO(IRQ_PRIO),
        .IRQ_VEC (IRQ_VEC),
        .LVL_W   (3),
        .VEC_W   (8)
    ) u_irq (
        .need  (need),
        .en    (en),
        .req   (irq_req),
        .level (irq_level),
        .vector(irq_vector)
    );

endmodule

// File: rtl/snd_port_chk.sv
module snd_port_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       bus_wr,
    input logic       bus_addr,
    input logic [7:0] bus_wdata,
    input logic [7:0] sample_out,
    input logic       irq_req,
    input logic       tick,
    input logic       need,
    input logic       en,
    input logic       urun
);
    a_r4_sample_latch: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr) |=> (sample_out == $past(bus_wdata)));

    a_r3_enable_load: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !bus_addr) |=> (en == $past(bus_wdata[7])));

    a_r5_tick_sets_need: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> need);

    a_r6_req_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && !bus_wr) |=> irq_req);

    a_r7_underrun_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && need && !(bus_wr && bus_addr)) |=> (urun && $stable(sample_out)));

    a_r10_coincident_write: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && bus_wr && bus_addr) |=> (need && urun == $past(urun)));
endmodule

bind snd_sample_port snd_port_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .sample_out(sample_out),
    .irq_req   (irq_req),
    .tick      (tick),
    .need      (need),
    .en        (en),
    .urun      (urun)
);

// File: tb/sim_snd_sample_port.sv
`timescale 1ns/1ps
module sim_snd_sample_port;
    localparam int RATE = 44_100;
    localparam int DIV  = 16;
    localparam int CLKF = RATE * DIV;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic       bus_addr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       irq_req;
    logic [2:0] irq_level;
    logic [7:0] irq_vector;
    logic [7:0] sample_out;

    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;

    snd_sample_port #(.CLK_HZ(CLKF), .RATE_HZ(RATE)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_req(irq_req),
        .irq_level(irq_level), .irq_vector(irq_vector), .sample_out(sample_out)
    );

    // reference model built from the requirements
    int         m_cnt;
    logic       m_need, m_en, m_ur;
    logic [7:0] m_smp;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_cnt <= 0; m_need <= 1'b1; m_en <= 1'b0; m_ur <= 1'b0; m_smp <= 8'h80;
        end else begin
            logic bnd, ws, wst, nn, ne, nu;
            logic [7:0] ns;
            bnd = (m_cnt == DIV - 1);
            ws  = bus_wr && bus_addr;
            wst = bus_wr && !bus_addr;
            nn = m_need; ne = m_en; nu = m_ur; ns = m_smp;
            if (wst) begin ne = bus_wdata[7]; if (bus_wdata[0]) nu = 1'b0; end
            if (ws) begin nn = 1'b0; ns = bus_wdata; end
            if (bnd) begin if (m_need && !ws) nu = 1'b1; nn = 1'b1; end
            m_need <= nn; m_en <= ne; m_ur <= nu; m_smp <= ns;
            m_cnt <= bnd ? 0 : m_cnt + 1;
        end
    end

    function automatic logic [7:0] exp_status(input logic n, input logic e, input logic u);
        return {n, e, 5'b00000, u};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        chk("R4 sample_out", 32'(sample_out), 32'(m_smp));
        chk("R6 irq_req", 32'(irq_req), 32'(m_need && m_en));
        if (bus_addr == 1'b0)
            chk("R2 status read", 32'(bus_rdata), 32'(exp_status(m_need, m_en, m_ur)));
        else
            chk("R2 sample read", 32'(bus_rdata), 32'(m_smp));
    endtask

    // drive one cycle of bus activity, then check after the edge
    task automatic step(input logic wr, input logic a, input logic [7:0] d);
        bus_wr = wr; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
        compare_all();
    endtask

    task automatic read_status(output logic [7:0] v);
        bus_wr = 1'b0; bus_addr = 1'b0;
        #1 v = bus_rdata;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        logic [7:0] st;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        // R1 reset state, held in reset
        chk("R1 sample_out", 32'(sample_out), 32'h80);
        chk("R1 irq_req", 32'(irq_req), 0);
        read_status(st);
        chk("R1 status", 32'(st), 32'h80);
        // R9 constants
        chk("R9 irq_level", 32'(irq_level), 5);
        chk("R9 irq_vector", 32'(irq_vector), 32'o74);
        rst_n = 1'b1;

        // R5 first boundary after DIV edges: clear need, then watch
        step(1'b1, 1'b1, 8'h11);
        chk("R5 need cleared", 32'(bus_rdata[7]), 32'(m_need));
        for (int i = 0; i < DIV - 2; i++) step(1'b0, 1'b0, 8'h00);
        read_status(st);
        chk("R5 need before boundary", 32'(st[7]), 0);
        step(1'b0, 1'b0, 8'h00);
        read_status(st);
        chk("R5 need at boundary", 32'(st[7]), 1);

        // R3 enable via 0x80, R6 request held
        step(1'b1, 1'b0, 8'h80);
        chk("R3 enable set", 32'(irq_req), 1);
        for (int i = 0; i < 5; i++) step(1'b0, 1'b1, 8'h00);
        chk("R6 request held", 32'(irq_req), 1);
        step(1'b1, 1'b0, 8'h00);
        chk("R3 enable cleared", 32'(irq_req), 0);

        // R7 underrun: leave need pending across a boundary
        for (int i = 0; i < DIV + 1; i++) step(1'b0, 1'b0, 8'h00);
        read_status(st);
        chk("R7 underrun set", 32'(st[0]), 1);
        chk("R7 sample held", 32'(sample_out), 32'h11);

        // R8 write 0 to bit0 keeps it, write 1 clears it
        step(1'b1, 1'b0, 8'h00);
        read_status(st);
        chk("R8 clear with 0 ignored", 32'(st[0]), 32'(m_ur));
        step(1'b1, 1'b0, 8'h01);
        read_status(st);
        chk("R8 clear with 1", 32'(st[0]), 32'(m_ur));

        // R10 sample write on the boundary cycle
        while (m_cnt != DIV - 1) step(1'b0, 1'b0, 8'h00);
        step(1'b1, 1'b1, 8'h5A);
        read_status(st);
        chk("R10 need stays set", 32'(st[7]), 1);
        chk("R10 no underrun", 32'(st[0]), 32'(m_ur));
        chk("R10 sample taken", 32'(sample_out), 32'h5A);

        // random traffic
        for (int i = 0; i < 4000; i++) begin
            int unsigned r;
            r = $urandom_range(0, 99);
            if (r < 70)       step(1'b0, 1'($urandom_range(0, 1)), 8'h00);
            else if (r < 85)  step(1'b1, 1'b1, 8'($urandom));
            else              step(1'b1, 1'b0, 8'($urandom));
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule